// File: doc/BRIEF.md
# Card Read-Block Receiver (SPI mode)

This block takes over the byte lane of an SPI link to a memory card once a read command has been accepted by the card. For each expected block it clocks out idle bytes (all ones) and watches the returned byte for the start-of-block token. It gives up after a fixed number of idle polls. Once the block has started it receives a fixed number of payload bytes and hands each one to a downstream consumer over a valid/ready byte port. It then reads the two check bytes that trail the payload and compares them against a CRC16 computed locally.

A transfer is launched by a one-cycle `start` strobe carrying the block count and the block size. It ends with a one-cycle `done` pulse. A status byte tells success apart from the two failure classes: a generic error, which covers a bad token or a token timeout, and a check-value mismatch. The byte lane uses a request/acknowledge handshake. Each acknowledged request is one full byte exchanged on the wire. While a payload byte is waiting for the consumer, no new exchange is requested, so a slow consumer simply pauses the serial clock.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for `start`.
- `ST_TOKEN`: polls for the token.
- `ST_PAYLOAD`: exchanges one payload byte.
- `ST_OFFER`: presents the byte to the consumer.
- `ST_CHK_HI` and `ST_CHK_LO`: receive the two check bytes.
- `ST_FINISH`: the one-cycle done state.

Its transitions are:
- idle→token on start.
- idle→finish when the count is zero.
- token→token on an all-ones byte.
- token→payload on the start token.
- token→chk_hi for a zero-size block.
- token→finish on a bad token or on timeout.
- payload→offer on each acknowledged byte.
- offer→payload when ready is seen and bytes remain.
- offer→chk_hi when ready is seen on the last byte.
- chk_hi→chk_lo.
- chk_lo→token when blocks remain.
- chk_lo→finish on the final block or on a mismatch.
- finish→idle.

Top module: `cardrd_block_rx`

## Requirements
- R1: After reset `xchg_req`, `pay_valid` and `done` are low and `status` is 8'h00. `xchg_tx` always carries 8'hFF.
- R2: Each acknowledged exchange that returns 8'hFF while waiting for a token counts as one poll. When `TIMEOUT_POLLS` polls in one block all return 8'hFF, the transfer ends with status 8'h80. A token on the last allowed poll is still accepted.
- R3: Only 8'hFE starts a block. Any other byte that is not 8'hFF, seen while waiting for a token, ends the whole transfer with status 8'h80 and forwards no payload for that block.
- R4: After the token, exactly `blk_size` payload bytes are forwarded on the valid/ready port, in wire order. They are followed by two check bytes that are not forwarded: high byte first, then low byte.
- R5: The check value is CRC16 with polynomial 16'h1021 and initial value 16'h0000, bits taken MSB first, computed over the payload. A mismatch ends the transfer with status 8'h08, and no further byte is exchanged.
- R6: Blocks repeat until `blk_count` blocks have passed, and the transfer then reports status 8'h00. A count of zero reports 8'h00 at once with no exchange.
- R7: `done` is a single-cycle pulse. `status` changes only in the cycle where `done` is high and holds between pulses.
- R8: While `pay_valid` is high, `xchg_req` is low. `pay_data` stays stable until `pay_ready` is seen.
- R9: A `start` strobe that arrives while a transfer is in progress is ignored.
- R10: Once raised, `xchg_req` stays high until `xchg_ack`. Each acknowledge consumes exactly one received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, taken only when idle |
| blk_count | input | CNT_W | Number of blocks to receive |
| blk_size | input | SZ_W | Payload bytes per block |
| xchg_req | output | 1 | Request one byte exchange on the SPI lane |
| xchg_tx | output | 8 | Byte to shift out (always 8'hFF) |
| xchg_ack | input | 1 | Exchange finished; `xchg_rx` valid |
| xchg_rx | input | 8 | Byte shifted in from the card |
| pay_valid | output | 1 | Payload byte available |
| pay_data | output | 8 | Payload byte |
| pay_ready | input | 1 | Consumer accepts the payload byte |
| status | output | 8 | Final code: 8'h00 ok, 8'h08 check mismatch, 8'h80 generic error |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bound checker watches the properties that hold every cycle:
- the request stays held until its acknowledge;
- no exchange is requested while a payload byte is pending, and that byte stays stable;
- `done` lasts one cycle, and `status` moves only with `done` and only to one of the three codes.

Several behaviours need the bench's card model and expected-value functions:
- the exact number of polls before a timeout;
- acceptance of a token on the last allowed poll;
- rejection of foreign tokens;
- payload order and count across several blocks;
- CRC mismatch detection that stops the lane;
- a `start` strobe being ignored in mid-transfer.

// File: rtl/cardrd_pkg.sv
package cardrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TOKEN,
        ST_PAYLOAD,
        ST_OFFER,
        ST_CHK_HI,
        ST_CHK_LO,
        ST_FINISH
    } rx_state_t;

    localparam logic [7:0] IDLE_BYTE   = 8'hFF;
    localparam logic [7:0] START_TOKEN = 8'hFE;

    localparam logic [7:0] CODE_OK      = 8'h00;
    localparam logic [7:0] CODE_CHKFAIL = 8'h08;
    localparam logic [7:0] CODE_GENERIC = 8'h80;

    localparam logic [15:0] CRC_POLY = 16'h1021;

    // One byte through the CRC16 register, most significant bit first.
    function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                               input logic [7:0]  data);
        logic [15:0] c;
        c = crc_in ^ {data, 8'h00};
        for (int b = 0; b < 8; b++) begin
            c = c[15] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/cardrd_down_cnt.sv
module cardrd_down_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == W'(1));
    assign zero = (cnt_q == '0);
endmodule

// File: rtl/cardrd_poll_timer.sv
module cardrd_poll_timer #(
    parameter int LIMIT = 3_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic final_poll
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(LIMIT - 1);

    logic [CW-1:0] polls_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            polls_q <= '0;
        end else if (clr) begin
            polls_q <= '0;
        end else if (tick) begin
            polls_q <= polls_q + 1'b1;
        end
    end

    // High while the poll about to complete is the last one permitted.
    assign final_poll = (polls_q == LAST_IDX);
endmodule

// File: rtl/cardrd_crc16.sv
module cardrd_crc16
    import cardrd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    logic [15:0] crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (clr) begin
            crc_q <= '0;
        end else if (en) begin
            crc_q <= crc16_step(crc_q, din);
        end
    end

    assign crc = crc_q;
endmodule

// File: rtl/cardrd_block_rx.sv
module cardrd_block_rx
    import cardrd_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int SZ_W          = 12,
    parameter int TIMEOUT_POLLS = 3_000_000,
    parameter bit CRC_CHECK     = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] blk_count,
    input  logic [SZ_W-1:0]  blk_size,
    output logic             xchg_req,
    output logic [7:0]       xchg_tx,
    input  logic             xchg_ack,
    input  logic [7:0]       xchg_rx,
    output logic             pay_valid,
    output logic [7:0]       pay_data,
    input  logic             pay_ready,
    output logic [7:0]       status,
    output logic             done
);
    rx_state_t state_q, state_d;

    logic       xchg_fire;
    logic       blk_load, blk_dec, blk_last;
    logic       byte_load, byte_dec, byte_last;
    logic       poll_clr, poll_tick, poll_final;
    logic       crc_clr, crc_en, chk_match;
    logic       size_we, data_we, hi_we, status_we;
    logic [7:0] status_d, status_q;
    logic [7:0] data_q, chk_hi_q;
    logic [SZ_W-1:0] size_q;
    logic       unused_zero_blk, unused_zero_byte;

    assign xchg_fire = xchg_req & xchg_ack;

    // ---------------- datapath helpers ----------------
    cardrd_down_cnt #(.W(CNT_W)) u_blk_left (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (blk_load),
        .load_val (blk_count),
        .dec      (blk_dec),
        .last     (blk_last),
        .zero     (unused_zero_blk)
    );

    cardrd_down_cnt #(.W(SZ_W)) u_byte_left (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (byte_load),
        .load_val (size_q),
        .dec      (byte_dec),
        .last     (byte_last),
        .zero     (unused_zero_byte)
    );

    cardrd_poll_timer #(.LIMIT(TIMEOUT_POLLS)) u_poll (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (poll_clr),
        .tick       (poll_tick),
        .final_poll (poll_final)
    );

    generate
        if (CRC_CHECK) begin : g_crc
            logic [15:0] crc_val;
            cardrd_crc16 u_crc (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (crc_clr),
                .en    (crc_en),
                .din   (xchg_rx),
                .crc   (crc_val)
            );
            assign chk_match = (crc_val == {chk_hi_q, xchg_rx});
        end else begin : g_nocrc
            logic unused_crc;
            assign unused_crc = crc_clr ^ crc_en;
            assign chk_match  = 1'b1;
        end
    endgenerate

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next-state and control ----------------
    always_comb begin
        state_d   = state_q;
        status_d  = status_q;
        status_we = 1'b0;
        size_we   = 1'b0;
        data_we   = 1'b0;
        hi_we     = 1'b0;
        blk_load  = 1'b0;
        blk_dec   = 1'b0;
        byte_load = 1'b0;
        byte_dec  = 1'b0;
        poll_clr  = 1'b0;
        poll_tick = 1'b0;
        crc_clr   = 1'b0;
        crc_en    = 1'b0;

        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    size_we  = 1'b1;
                    blk_load = 1'b1;
                    poll_clr = 1'b1;
                    crc_clr  = 1'b1;
                    if (blk_count == '0) begin
                        status_d  = CODE_OK;
                        status_we = 1'b1;
                        state_d   = ST_FINISH;
                    end else begin
                        state_d = ST_TOKEN;
                    end
                end
            end

            ST_TOKEN: begin
                if (xchg_fire) begin
                    if (xchg_rx == IDLE_BYTE) begin
                        if (poll_final) begin
                            status_d  = CODE_GENERIC;
                            status_we = 1'b1;
                            state_d   = ST_FINISH;
                        end else begin
                            poll_tick = 1'b1;
                        end
                    end else if (xchg_rx == START_TOKEN) begin
                        byte_load = 1'b1;
                        state_d   = (size_q == '0) ? ST_CHK_HI : ST_PAYLOAD;
                    end else begin
                        status_d  = CODE_GENERIC;
                        status_we = 1'b1;
                        state_d   = ST_FINISH;
                    end
                end
            end

            ST_PAYLOAD: begin
                if (xchg_fire) begin
                    data_we = 1'b1;
                    crc_en  = 1'b1;
                    state_d = ST_OFFER;
                end
            end

            ST_OFFER: begin
                if (pay_ready) begin
                    byte_dec = 1'b1;
                    state_d  = byte_last ? ST_CHK_HI : ST_PAYLOAD;
                end
            end

            ST_CHK_HI: begin
                if (xchg_fire) begin
                    hi_we   = 1'b1;
                    state_d = ST_CHK_LO;
                end
            end

            ST_CHK_LO: begin
                if (xchg_fire) begin
                    if (!chk_match) begin
                        status_d  = CODE_CHKFAIL;
                        status_we = 1'b1;
                        state_d   = ST_FINISH;
                    end else if (blk_last) begin
                        status_d  = CODE_OK;
                        status_we = 1'b1;
                        state_d   = ST_FINISH;
                    end else begin
                        blk_dec  = 1'b1;
                        poll_clr = 1'b1;
                        crc_clr  = 1'b1;
                        state_d  = ST_TOKEN;
                    end
                end
            end

            ST_FINISH: begin
                state_d = ST_IDLE;
            end

            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // ---------------- data registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= CODE_OK;
            data_q   <= '0;
            chk_hi_q <= '0;
            size_q   <= '0;
        end else begin
            if (status_we) status_q <= status_d;
            if (data_we)   data_q   <= xchg_rx;
            if (hi_we)     chk_hi_q <= xchg_rx;
            if (size_we)   size_q   <= blk_size;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        xchg_req  = 1'b0;
        pay_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_TOKEN, ST_PAYLOAD, ST_CHK_HI, ST_CHK_LO: xchg_req  = 1'b1;
            ST_OFFER:                                   pay_valid = 1'b1;
            ST_FINISH:                                  done      = 1'b1;
            default: ;
        endcase
    end

    assign xchg_tx  = IDLE_BYTE;
    assign pay_data = data_q;
    assign status   = status_q;

endmodule

// File: rtl/cardrd_block_rx_chk.sv
module cardrd_block_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       xchg_req,
    input logic       xchg_ack,
    input logic       pay_valid,
    input logic [7:0] pay_data,
    input logic       pay_ready,
    input logic [7:0] status,
    input logic       done
);
    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_req && !xchg_ack |=> xchg_req);

    assert_no_xchg_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> !xchg_req);

    assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid && !pay_ready |=> pay_valid && $stable(pay_data));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_status_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(status));

    assert_status_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status == 8'h00 || status == 8'h08 || status == 8'h80));

    assert_offer_not_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> !done);
endmodule

bind cardrd_block_rx cardrd_block_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xchg_req  (xchg_req),
    .xchg_ack  (xchg_ack),
    .pay_valid (pay_valid),
    .pay_data  (pay_data),
    .pay_ready (pay_ready),
    .status    (status),
    .done      (done)
);

// File: tb/cardrd_block_rx_test.sv
module cardrd_block_rx_test;
    localparam int TOUT = 40;
    localparam int CW   = 8;
    localparam int SW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] blk_count = '0;
    logic [SW-1:0] blk_size = '0;
    logic          xchg_req, xchg_ack;
    logic [7:0]    xchg_tx, xchg_rx;
    logic          pay_valid, pay_ready, done;
    logic [7:0]    pay_data, status;

    logic rnd_ready = 1'b1;
    logic force_low = 1'b0;
    logic rewind = 1'b0;
    assign pay_ready = rnd_ready & ~force_low;

    always #2 clk = ~clk;

    cardrd_block_rx #(.CNT_W(CW), .SZ_W(SW), .TIMEOUT_POLLS(TOUT)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_count(blk_count),
        .blk_size(blk_size), .xchg_req(xchg_req), .xchg_tx(xchg_tx),
        .xchg_ack(xchg_ack), .xchg_rx(xchg_rx), .pay_valid(pay_valid),
        .pay_data(pay_data), .pay_ready(pay_ready), .status(status), .done(done)
    );

    int n_tests = 0, n_fail = 0;
    logic [7:0] stream [0:4095];
    int slen = 0;
    logic [7:0] exp_pay [0:4095];
    int exp_n, exp_xchg;
    logic [7:0] exp_status;
    logic [7:0] got [0:4095];
    int gcount = 0, nacks = 0, ptr = 0, wait_cnt = 0, done_cnt = 0;
    logic [7:0] last_status;
    int r8_viol = 0, done_wide = 0;
    logic prev_done = 1'b0;
    int cycles = 0;

    // Card model: answers each request after 0..2 idle cycles.
    always @(posedge clk) begin
        if (!rst_n || rewind) begin
            xchg_ack <= 1'b0; xchg_rx <= 8'hFF; ptr <= 0; nacks <= 0; wait_cnt <= 0;
        end else if (xchg_ack) begin
            xchg_ack <= 1'b0;
        end else if (xchg_req) begin
            if (wait_cnt == 0) begin
                xchg_ack <= 1'b1;
                xchg_rx  <= (ptr < slen) ? stream[ptr] : 8'hFF;
                ptr      <= ptr + 1;
                nacks    <= nacks + 1;
                wait_cnt <= int'($urandom % 3);
            end else begin
                wait_cnt <= wait_cnt - 1;
            end
        end
    end

    initial forever begin
        @(posedge clk); #1;
        rnd_ready = ($urandom % 4) != 0;
    end

    // Monitors, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pay_valid && pay_ready) begin got[gcount] = pay_data; gcount++; end
            if (pay_valid && xchg_req) r8_viol++;
            if (done) begin done_cnt++; last_status = status; end
            if (done && prev_done) done_wide++;
            prev_done = done;
        end
    end

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int first, input int n);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < n; i++) begin
            c ^= {exp_pay[first + i], 8'h00};
            for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    function automatic void push(input logic [7:0] b);
        stream[slen] = b; slen++;
    endfunction

    // kind: 0 none, 1 foreign token, 2 check mismatch, 3 token timeout
    task automatic build(input int nblk, input int size, input int bad_blk,
                         input int kind, input int pre_fixed);
        logic [15:0] c;
        int pre;
        slen = 0; exp_n = 0; exp_xchg = 0; exp_status = 8'h00;
        for (int b = 0; b < nblk; b++) begin
            pre = (pre_fixed >= 0) ? pre_fixed : int'($urandom % 5);
            if (b == bad_blk && kind == 3) begin
                exp_xchg += TOUT; exp_status = 8'h80; return;
            end
            for (int i = 0; i < pre; i++) push(8'hFF);
            if (b == bad_blk && kind == 1) begin
                logic [7:0] t;
                t = 8'($urandom % 254);
                push(t); exp_xchg += pre + 1; exp_status = 8'h80; return;
            end
            push(8'hFE);
            for (int i = 0; i < size; i++) begin
                exp_pay[exp_n + i] = 8'($urandom);
                push(exp_pay[exp_n + i]);
            end
            c = ref_crc(exp_n, size);
            exp_n += size;
            if (b == bad_blk && kind == 2) c ^= 16'(1 << ($urandom % 16));
            push(c[15:8]); push(c[7:0]);
            exp_xchg += pre + 1 + size + 2;
            if (b == bad_blk && kind == 2) begin exp_status = 8'h08; return; end
        end
    endtask

    task automatic run(input string req, input int nblk, input int size,
                       input int restart_at, input int stall);
        int base;
        bit seen = 0, stalled = 0;
        base = done_cnt; gcount = 0; r8_viol = 0;
        @(negedge clk);
        blk_count = CW'(nblk); blk_size = SW'(size); start = 1'b1; rewind = 1'b1;
        @(negedge clk);
        start = 1'b0; rewind = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done_cnt != base) begin seen = 1; break; end
            if (i == restart_at) begin start = 1'b1; blk_count = CW'(nblk + 3); end
            else if (i == restart_at + 1) begin start = 1'b0; blk_count = CW'(nblk); end
            if (stall > 0 && !stalled && pay_valid) begin
                logic [7:0] held;
                int req_seen = 0, moved = 0;
                stalled = 1; force_low = 1'b1; held = pay_data;
                for (int k = 0; k < stall; k++) begin
                    @(negedge clk);
                    if (xchg_req) req_seen++;
                    if (!pay_valid || pay_data != held) moved++;
                end
                force_low = 1'b0;
                chk(req_seen == 0, "R8 exchange while stalled", req_seen, 0);
                chk(moved == 0, "R8 payload held during stall", moved, 0);
            end
        end
        start = 1'b0;
        chk(seen, {req, " done reached"}, seen, 1);
        repeat (6) @(negedge clk);
        chk(last_status == exp_status, {req, " status"}, last_status, exp_status);
        chk(gcount == exp_n, {req, " payload count"}, gcount, exp_n);
        for (int i = 0; i < exp_n && i < gcount; i++)
            if (got[i] != exp_pay[i]) begin
                chk(0, {req, " payload byte"}, got[i], exp_pay[i]); break;
            end
        chk(nacks == exp_xchg, {req, " exchange count"}, nacks, exp_xchg);
        chk(done_cnt == base + 1 && status == exp_status, "R7 single done, status held",
            done_cnt - base, 1);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(!xchg_req && !pay_valid && !done, "R1 outputs idle after reset",
            {xchg_req, pay_valid, done}, 0);
        chk(status == 8'h00 && xchg_tx == 8'hFF, "R1 status/tx after reset",
            {status, xchg_tx}, 16'h00FF);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        build(1, 4, -1, 0, 2);      run("R4 single block", 1, 4, -1, 0);
        build(3, 9, -1, 0, -1);     run("R6 three blocks", 3, 9, -1, 0);
        build(0, 4, -1, 0, 0);      run("R6 zero count", 0, 4, -1, 0);
        build(2, 5, 1, 1, 1);       run("R3 foreign token", 2, 5, -1, 0);
        build(1, 5, 0, 3, 0);       run("R2 token timeout", 1, 5, -1, 0);
        build(2, 3, 1, 3, 0);       run("R2 timeout second block", 2, 3, -1, 0);
        build(1, 6, -1, 0, TOUT - 1); run("R2 token on last poll", 1, 6, -1, 0);
        build(3, 7, 1, 2, -1);      run("R5 check mismatch", 3, 7, -1, 0);
        build(2, 8, -1, 0, 1);      run("R9 start while busy", 2, 8, 10, 0);
        build(1, 6, -1, 0, 0);      run("R8 consumer stall", 1, 6, -1, 25);
        build(2, 1, -1, 0, 3);      run("R10 one-byte blocks", 2, 1, -1, 0);
        chk(r8_viol == 0 && done_wide == 0, "R8 no request with pending byte",
            r8_viol, 0);

        for (int t = 0; t < 22; t++) begin
            int nb, sz, kind, badb;
            nb = 1 + int'($urandom % 3);
            sz = 1 + int'($urandom % 16);
            kind = int'($urandom % 6);
            if (kind > 3) kind = 0;
            badb = int'($urandom % nb);
            build(nb, sz, badb, kind, -1);
            run("R5 R6 random transfer", nb, sz, -1, 0);
        end
        summary();
    end
endmodule